// File: doc/BRIEF.md
# Peripheral Clock Divider Selector

This block turns a requested clock frequency into a source choice and a divider setting for one peripheral clock. It then produces the divided clock with a counter. A single update pulse starts a calculation on the mode, requested rate and general-source rate presented at the ports. The block runs one shared iterative divider several times. It first checks whether the fast general source can reach the request. If the divider field would be too wide, it tries the 24 MHz crystal instead. When a setting can be stored, the block commits it and then computes the rate it actually delivers, which is read back on `rateHz`.

Three modes are handled. The storage-card mode allows for a fixed divide-by-two stage after the block. It uses a 6-bit divider and may fall back to the crystal. The serial-peripheral mode always uses the general source with a 7-bit divider. The converter mode always divides the crystal with an 8-bit divider. A request that cannot be met sets an error flag and leaves every stored setting as it was. The divided output `divClk` is produced from `clk`, which stands in for the selected source. A new ratio is picked up only when the counter wraps.

Top module: `periph_clk_divsel`

## Requirements
- R1: After reset, `srcXtal`, `divField`, `rateHz`, `cfgErr` and `busy` are 0, and `divClk` is 1.
- R2: Storage mode (`modeSel`=0) computes d = max(1, ceil(floor(genHz/2)/reqHz)). If d <= 63, the block selects the general source (`srcXtal`=0) and sets `divField` = d-1.
- R3: In storage mode with d > 63, the block computes d2 = max(1, ceil(12,000,000/reqHz)). If d2 <= 63, it selects the crystal (`srcXtal`=1) and sets `divField` = d2-1.
- R4: In storage mode with d2 > 63, `cfgErr` is 1 and `srcXtal`, `divField` and `rateHz` keep their previous values.
- R5: Serial mode (`modeSel`=1) computes d = max(1, ceil(genHz/reqHz)). If d <= 128 (field below 128), it selects the general source and sets `divField` = d-1. Otherwise it sets `cfgErr` and changes nothing.
- R6: Converter mode (`modeSel`=2) computes d = max(1, ceil(24,000,000/reqHz)). If d <= 256, it selects the crystal and sets `divField` = d-1. Otherwise it sets `cfgErr` and changes nothing.
- R7: A request with `reqHz`=0, or with `modeSel`=3, sets `cfgErr` and changes nothing.
- R8: After a successful update, `rateHz` = floor(source/(divField+1)). The source is 24,000,000 when `srcXtal`=1; otherwise it is the `genHz` captured at the update.
- R9: An update is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the result is ready. `done` is a one-cycle pulse at which all results are valid, and an update pulse seen while busy has no effect.
- R10: `divClk` repeats every N = `divField`+1 cycles of `clk` and is high for ceil(N/2) of them. A new ratio takes effect at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the source for the divided output |
| rstN | input | 1 | Active-low synchronous reset |
| update | input | 1 | Start a calculation with the current inputs |
| modeSel | input | 2 | 0 storage card, 1 serial peripheral, 2 converter, 3 invalid |
| reqHz | input | 32 | Requested frequency in Hz |
| genHz | input | 32 | Current general-source rate in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| cfgErr | output | 1 | Last request could not be met |
| srcXtal | output | 1 | 1 selects the crystal, 0 the general source |
| divField | output | 8 | Stored divider minus one |
| rateHz | output | 32 | Resulting output rate in Hz |
| divClk | output | 1 | Counter-divided clock |

## Verification
Directed requests sit exactly on the divider limits: 63 against 64 in storage mode, 128 against 129 in serial mode, and 256 against 259 in converter mode. These separate an off-by-one in a limit from a correct fallback or error. Other directed cases cover requests above half the general rate, which must clamp the divider to one, and crystal fallbacks that themselves overflow, which must leave the old setting in place. Random requests from four frequency bands, mixed with invalid modes and zero requests, are compared against a model of the ceiling arithmetic. This catches rounding errors, such as floor instead of ceiling or a missing halving. The output waveform is measured for odd and even ratios, which checks both the period and the high time.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int FIELD_W = 8;

  typedef enum logic [1:0] {
    MODE_STORE  = 2'd0,
    MODE_SERIAL = 2'd1,
    MODE_ADC    = 2'd2,
    MODE_BAD    = 2'd3
  } modeSel_e;

  typedef enum logic [2:0] {
    NUM_GEN_HALF,
    NUM_GEN,
    NUM_XTAL,
    NUM_XTAL_HALF,
    NUM_SRC
  } numSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               latchIn;
    logic               divStart;
    numSel_e            numSel;
    logic               denField;
    logic               loadCfg;
    logic               cfgXtal;
    logic [FIELD_W-1:0] cfgField;
    logic               loadRate;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkdiv_ceil_divider.sv
module clkdiv_ceil_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W:0]   quoCeil
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    remR;
  logic [W-1:0]  quoR;
  logic [W-1:0]  denR;
  logic [CW-1:0] stepR;
  logic          runR;
  logic          doneR;
  logic [W:0]    trial;
  logic          fits;

  // one restoring step per cycle
  always_comb begin
    trial = {remR[W-1:0], quoR[W-1]};
    fits  = trial >= {1'b0, denR};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      denR  <= '0;
      stepR <= '0;
      runR  <= 1'b0;
      doneR <= 1'b0;
    end else if (start) begin
      remR  <= '0;
      quoR  <= num;
      denR  <= den;
      stepR <= CW'(W);
      runR  <= 1'b1;
      doneR <= 1'b0;
    end else if (runR) begin
      remR  <= fits ? (trial - {1'b0, denR}) : trial;
      quoR  <= {quoR[W-2:0], fits};
      stepR <= stepR - 1'b1;
      if (stepR == CW'(1)) begin
        runR  <= 1'b0;
        doneR <= 1'b1;
      end
    end else begin
      doneR <= 1'b0;
    end
  end

  assign done    = doneR;
  assign quo     = quoR;
  // rounding up from the remainder avoids widening the numerator
  assign quoCeil = {1'b0, quoR} + (W + 1)'(remR != '0);
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] field,
  output logic          divClk
);
  logic [FW:0]   actN;
  logic [FW-1:0] cntR;
  logic [FW:0]   halfN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actN <= (FW + 1)'(1);
      cntR <= '0;
    end else if ({1'b0, cntR} == actN - 1'b1) begin
      cntR <= '0;
      actN <= {1'b0, field} + 1'b1;  // new ratio only at wrap
    end else begin
      cntR <= cntR + 1'b1;
    end
  end

  assign halfN  = (actN + 1'b1) >> 1;
  assign divClk = {1'b0, cntR} < halfN;
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int RATE_W  = 32,
  parameter int XTAL_HZ = 24_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        stb,
  input  logic [RATE_W-1:0]  reqHz,
  input  logic [RATE_W-1:0]  genHz,
  output logic               divDone,
  output logic [RATE_W:0]    quoCeil,
  output logic               srcXtal,
  output logic [FIELD_W-1:0] divField,
  output logic [RATE_W-1:0]  rateHz,
  output logic               divClk
);
  localparam logic [RATE_W-1:0] XTAL_V      = RATE_W'(XTAL_HZ);
  localparam logic [RATE_W-1:0] XTAL_HALF_V = RATE_W'(XTAL_HZ / 2);

  logic [RATE_W-1:0]  reqR;
  logic [RATE_W-1:0]  genR;
  logic               xtalR;
  logic [FIELD_W-1:0] fieldR;
  logic [RATE_W-1:0]  rateR;
  logic [RATE_W-1:0]  numMux;
  logic [RATE_W-1:0]  denMux;
  logic [RATE_W-1:0]  quoFloor;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqR   <= '0;
      genR   <= '0;
      xtalR  <= 1'b0;
      fieldR <= '0;
      rateR  <= '0;
    end else begin
      if (stb.latchIn) begin
        reqR <= reqHz;
        genR <= genHz;
      end
      if (stb.loadCfg) begin
        xtalR  <= stb.cfgXtal;
        fieldR <= stb.cfgField;
      end
      if (stb.loadRate) rateR <= quoFloor;
    end
  end

  always_comb begin
    case (stb.numSel)
      NUM_GEN_HALF:  numMux = genR >> 1;
      NUM_GEN:       numMux = genR;
      NUM_XTAL:      numMux = XTAL_V;
      NUM_XTAL_HALF: numMux = XTAL_HALF_V;
      NUM_SRC:       numMux = xtalR ? XTAL_V : genR;
      default:       numMux = genR;
    endcase
    denMux = stb.denField ? (RATE_W'(fieldR) + 1'b1) : reqR;
  end

  clkdiv_ceil_divider #(.W(RATE_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .start   (stb.divStart),
    .num     (numMux),
    .den     (denMux),
    .done    (divDone),
    .quo     (quoFloor),
    .quoCeil (quoCeil)
  );

  clkdiv_wave #(.FW(FIELD_W)) u_wave (
    .clk    (clk),
    .rstN   (rstN),
    .field  (fieldR),
    .divClk (divClk)
  );

  assign srcXtal  = xtalR;
  assign divField = fieldR;
  assign rateHz   = rateR;
endmodule

// File: rtl/clkdiv_control.sv
module clkdiv_control
  import clkdiv_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int STORE_DIV_W = 6,
  parameter int SPI_DIV_W   = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            update,
  input  logic [1:0]      modeSel,
  input  logic            reqZero,
  input  logic            divDone,
  input  logic [RATE_W:0] quoCeil,
  output ctrlStrobe_t     stb,
  output logic            busy,
  output logic            done,
  output logic            cfgErr
);
  localparam logic [RATE_W:0] STORE_MAX = (RATE_W + 1)'((1 << STORE_DIV_W) - 1);
  localparam logic [RATE_W:0] SPI_MAX   = (RATE_W + 1)'(1 << SPI_DIV_W);
  localparam logic [RATE_W:0] ADC_MAX   = (RATE_W + 1)'(1 << FIELD_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_W1, ST_S2, ST_W2, ST_S3, ST_W3, ST_FIN
  } state_e;

  state_e          stateR, stateNx;
  modeSel_e        modeR;
  logic            errR;
  logic            errSet;
  logic            badReq;
  logic [RATE_W:0] dVal;

  assign badReq = (modeSel_e'(modeSel) == MODE_BAD) || reqZero;
  assign dVal   = (quoCeil == '0) ? (RATE_W + 1)'(1) : quoCeil;

  always_comb begin
    stb          = '0;
    stb.numSel   = NUM_GEN;
    stb.cfgField = FIELD_W'(dVal - 1'b1);
    errSet       = 1'b0;
    stateNx      = stateR;
    case (stateR)
      ST_IDLE: if (update) begin
        stb.latchIn = 1'b1;
        stateNx     = badReq ? ST_FIN : ST_S1;
      end
      ST_S1: begin
        stb.divStart = 1'b1;
        case (modeR)
          MODE_STORE:  stb.numSel = NUM_GEN_HALF;
          MODE_SERIAL: stb.numSel = NUM_GEN;
          default:     stb.numSel = NUM_XTAL;
        endcase
        stateNx = ST_W1;
      end
      ST_W1: if (divDone) begin
        case (modeR)
          MODE_STORE: begin
            if (dVal <= STORE_MAX) begin
              stb.loadCfg = 1'b1;
              stateNx     = ST_S3;
            end else begin
              stateNx = ST_S2;  // fall back to the crystal
            end
          end
          MODE_SERIAL: begin
            if (dVal <= SPI_MAX) begin
              stb.loadCfg = 1'b1;
              stateNx     = ST_S3;
            end else begin
              errSet  = 1'b1;
              stateNx = ST_FIN;
            end
          end
          MODE_ADC: begin
            if (dVal <= ADC_MAX) begin
              stb.loadCfg = 1'b1;
              stb.cfgXtal = 1'b1;
              stateNx     = ST_S3;
            end else begin
              errSet  = 1'b1;
              stateNx = ST_FIN;
            end
          end
          default: begin
            errSet  = 1'b1;
            stateNx = ST_FIN;
          end
        endcase
      end
      ST_S2: begin
        stb.divStart = 1'b1;
        stb.numSel   = NUM_XTAL_HALF;
        stateNx      = ST_W2;
      end
      ST_W2: if (divDone) begin
        if (dVal <= STORE_MAX) begin
          stb.loadCfg = 1'b1;
          stb.cfgXtal = 1'b1;
          stateNx     = ST_S3;
        end else begin
          errSet  = 1'b1;
          stateNx = ST_FIN;
        end
      end
      ST_S3: begin
        stb.divStart = 1'b1;
        stb.numSel   = NUM_SRC;
        stb.denField = 1'b1;
        stateNx      = ST_W3;
      end
      ST_W3: if (divDone) begin
        stb.loadRate = 1'b1;
        stateNx      = ST_FIN;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      modeR  <= MODE_STORE;
      errR   <= 1'b0;
    end else begin
      stateR <= stateNx;
      if (stateR == ST_IDLE && update) begin
        modeR <= modeSel_e'(modeSel);
        errR  <= badReq;
      end else if (errSet) begin
        errR <= 1'b1;
      end
    end
  end

  assign busy   = stateR != ST_IDLE;
  assign done   = stateR == ST_FIN;
  assign cfgErr = errR;
endmodule

// File: rtl/periph_clk_divsel.sv
module periph_clk_divsel
  import clkdiv_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int XTAL_HZ     = 24_000_000,
  parameter int STORE_DIV_W = 6,
  parameter int SPI_DIV_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               update,
  input  logic [1:0]         modeSel,
  input  logic [RATE_W-1:0]  reqHz,
  input  logic [RATE_W-1:0]  genHz,
  output logic               busy,
  output logic               done,
  output logic               cfgErr,
  output logic               srcXtal,
  output logic [FIELD_W-1:0] divField,
  output logic [RATE_W-1:0]  rateHz,
  output logic               divClk
);
  ctrlStrobe_t     stb;
  logic            divDone;
  logic [RATE_W:0] quoCeil;

  clkdiv_control #(
    .RATE_W      (RATE_W),
    .STORE_DIV_W (STORE_DIV_W),
    .SPI_DIV_W   (SPI_DIV_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .update  (update),
    .modeSel (modeSel),
    .reqZero (reqHz == '0),
    .divDone (divDone),
    .quoCeil (quoCeil),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .cfgErr  (cfgErr)
  );

  clkdiv_datapath #(
    .RATE_W  (RATE_W),
    .XTAL_HZ (XTAL_HZ)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqHz    (reqHz),
    .genHz    (genHz),
    .divDone  (divDone),
    .quoCeil  (quoCeil),
    .srcXtal  (srcXtal),
    .divField (divField),
    .rateHz   (rateHz),
    .divClk   (divClk)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int RATE_W      = 32,
  parameter int STORE_DIV_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              update,
  input logic [1:0]        modeSel,
  input logic              busy,
  input logic              done,
  input logic              cfgErr,
  input logic              srcXtal,
  input logic [7:0]        divField,
  input logic [RATE_W-1:0] rateHz
);
  logic              snapXtal;
  logic [7:0]        snapField;
  logic [RATE_W-1:0] snapRate;
  logic [1:0]        snapMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapXtal  <= 1'b0;
      snapField <= '0;
      snapRate  <= '0;
      snapMode  <= '0;
    end else if (update && !busy) begin
      snapXtal  <= srcXtal;
      snapField <= divField;
      snapRate  <= rateHz;
      snapMode  <= modeSel;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !update) |=> ($stable(divField) && $stable(srcXtal) && $stable(rateHz)));

  a_r4_err_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (done && cfgErr) |-> (divField == snapField && srcXtal == snapXtal && rateHz == snapRate));

  a_r2_store_range: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cfgErr && snapMode == 2'd0) |-> (32'(divField) < (1 << STORE_DIV_W) - 1));

  a_r5_serial_general: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cfgErr && snapMode == 2'd1) |-> !srcXtal);

  a_r6_adc_crystal: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cfgErr && snapMode == 2'd2) |-> srcXtal);

  a_r7_bad_mode_err: assert property (@(posedge clk) disable iff (!rstN)
    (done && snapMode == 2'd3) |-> cfgErr);
endmodule

bind periph_clk_divsel clkdiv_checker #(
  .RATE_W      (RATE_W),
  .STORE_DIV_W (STORE_DIV_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .update   (update),
  .modeSel  (modeSel),
  .busy     (busy),
  .done     (done),
  .cfgErr   (cfgErr),
  .srcXtal  (srcXtal),
  .divField (divField),
  .rateHz   (rateHz)
);

// File: tb/periph_clk_divsel_test.sv
module periph_clk_divsel_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        update;
  logic [1:0]  modeSel;
  logic [31:0] reqHz;
  logic [31:0] genHz;
  logic        busy, done, cfgErr, srcXtal, divClk;
  logic [7:0]  divField;
  logic [31:0] rateHz;

  int     checks = 0;
  int     fails = 0;
  bit     finished = 0;
  bit     expX = 0;
  longint expF = 0;
  longint expR = 0;

  always #4 clk = ~clk;

  periph_clk_divsel uut (
    .clk(clk), .rstN(rstN), .update(update), .modeSel(modeSel),
    .reqHz(reqHz), .genHz(genHz), .busy(busy), .done(done),
    .cfgErr(cfgErr), .srcXtal(srcXtal), .divField(divField),
    .rateHz(rateHz), .divClk(divClk)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint cdiv(longint a, longint b);
    longint q = (a + b - 1) / b;
    return (q == 0) ? 1 : q;
  endfunction

  task automatic runReq(int mode, longint req, longint gen);
    bit     e = 1;
    bit     x = expX;
    longint f = expF;
    longint d;
    longint r;
    string  tag;
    int     n = 0;
    tag = "R7";
    if (req != 0 && mode != 3) begin
      case (mode)
        0: begin
          d = cdiv(gen / 2, req);
          if (d <= 63) begin e = 0; x = 0; f = d - 1; tag = "R2"; end
          else begin
            d = cdiv(12000000, req);
            if (d <= 63) begin e = 0; x = 1; f = d - 1; tag = "R3"; end
            else tag = "R4";
          end
        end
        1: begin
          tag = "R5";
          d = cdiv(gen, req);
          if (d <= 128) begin e = 0; x = 0; f = d - 1; end
        end
        default: begin
          tag = "R6";
          d = cdiv(24000000, req);
          if (d <= 256) begin e = 0; x = 1; f = d - 1; end
        end
      endcase
    end
    r = e ? expR : ((x ? 64'd24000000 : gen) / (f + 1));
    @(negedge clk);
    modeSel = 2'(mode); reqHz = req[31:0]; genHz = gen[31:0]; update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    chk("R9 busy after accept", longint'(busy), 1);
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk("R9 done seen", longint'(done), 1);
    chk({tag, " err"}, longint'(cfgErr), longint'(e));
    chk({tag, " src"}, longint'(srcXtal), longint'(x));
    chk({tag, " field"}, longint'(divField), f);
    chk("R8 rate", longint'(rateHz), r);
    expX = x; expF = f; expR = r;
    @(negedge clk);
    chk("R9 done one cycle", longint'(done), 0);
  endtask

  task automatic waveCheck(int nRatio);
    int g = 0;
    int hi = 0;
    int lo = 0;
    repeat (600) @(negedge clk);
    while (divClk && g < 600) begin @(negedge clk); g++; end
    while (!divClk && g < 1200) begin @(negedge clk); g++; end
    while (divClk && hi < 600) begin hi++; @(negedge clk); end
    while (!divClk && lo < 600) begin lo++; @(negedge clk); end
    chk("R10 high cycles", hi, (nRatio + 1) / 2);
    chk("R10 low cycles", lo, nRatio / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedDummy;
    rstN = 1'b0; update = 1'b0; modeSel = '0; reqHz = '0; genHz = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 srcXtal", longint'(srcXtal), 0);
    chk("R1 divField", longint'(divField), 0);
    chk("R1 rateHz", longint'(rateHz), 0);
    chk("R1 cfgErr", longint'(cfgErr), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 divClk", longint'(divClk), 1);

    runReq(0, 50000000, 594000000);   // R2 d=6
    waveCheck(6);                     // R10 even
    runReq(0, 5000000, 630000000);    // R2 d=63 boundary
    runReq(0, 5000000, 640000000);    // R3 d=64 -> crystal d=3
    waveCheck(3);                     // R10 odd
    runReq(0, 400000, 594000000);     // R3
    runReq(0, 100000, 594000000);     // R4 overflow keeps state
    runReq(0, 80000000, 100000000);   // R2 clamp to 1
    runReq(1, 5000000, 594000000);    // R5 d=119
    runReq(1, 5000000, 640000000);    // R5 d=128 boundary
    runReq(1, 5000000, 645000000);    // R5 d=129 error
    runReq(2, 1000000, 594000000);    // R6 d=24
    runReq(2, 2400000, 594000000);    // R6 d=10
    waveCheck(10);                    // R10
    runReq(2, 93750, 594000000);      // R6 d=256 boundary
    runReq(2, 93000, 594000000);      // R6 overflow
    runReq(3, 1000000, 594000000);    // R7 bad mode
    runReq(1, 0, 594000000);          // R7 zero request

    // R9: second update during busy is ignored
    @(negedge clk);
    modeSel = 2'd0; reqHz = 32'd50000000; genHz = 32'd594000000; update = 1'b1;
    @(negedge clk);
    modeSel = 2'd2; reqHz = 32'd1000000; genHz = 32'd100000000;
    @(negedge clk);
    update = 1'b0;
    begin
      int n = 0;
      while (!done && n < 1000) begin @(negedge clk); n++; end
    end
    chk("R9 ignored update field", longint'(divField), 5);
    chk("R9 ignored update src", longint'(srcXtal), 0);
    chk("R9 ignored update rate", longint'(rateHz), 99000000);
    expX = 0; expF = 5; expR = 99000000;
    @(negedge clk);

    seedDummy = $urandom(32'd777);
    for (int i = 0; i < 200; i++) begin
      int     mode;
      int     band;
      longint req;
      longint gen;
      mode = $urandom_range(9, 0);
      mode = (mode == 9) ? 3 : (mode % 3);
      band = $urandom_range(3, 0);
      gen  = longint'($urandom_range(1600, 100)) * 1000000;
      case (band)
        0:       req = $urandom_range(400000, 50000);
        1:       req = $urandom_range(20000000, 1000000);
        2:       req = $urandom_range(200000000, 20000000);
        default: req = $urandom_range(2000000, 80000);
      endcase
      if ($urandom_range(19, 0) == 0) req = 0;
      runReq(mode, req, gen);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule